// File: doc/BRIEF.md
# Predicated Two-Operand Microcore

A compact 32-bit processor that runs entirely out of a private 512-word memory. That memory is the whole state of the program: code, data and working values share one address space. Apart from it, the core keeps only a program counter and two condition flags, carry (C) and zero (Z). It has no stack, no interrupt logic and no separate register file. Each instruction is one 32-bit word that names a 9-bit destination address and a 9-bit source. The source is either another memory word or a 9-bit literal. The result goes back to the destination word.

There is no indirect addressing, so programs patch their own instruction words when they need a computed address. Such a patch is visible to the very next fetch. Every instruction carries a 4-bit predicate that is evaluated against the current C and Z. It also carries three enables that decide separately whether C, Z and the destination word are updated. An instruction whose predicate fails still takes its single cycle, so timing does not depend on the data.

The sixteen addresses above the plain memory decode to special registers: an input port, an output port register, and fourteen reserved slots. Before a run, a host loads code and data through a preload port while the core is halted. The same port reads back any address at any time, and a run level starts and stops execution.

Top module: `pcore_top`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, the next state is pc = 0, C = 0, Z = 0 and `out_port` = 0. Plain memory words are not cleared.
- R2: The instruction word is laid out as opcode[31:26], write-Z[25], write-C[24], write-result[23], immediate[22], predicate[21:18], destination[17:9], source[8:0]. ADD (6'h02) computes dest + src with C taking the carry out. SUB (6'h03) computes dest - src with C taking the borrow (set when dest < src, unsigned).
- R3: C changes only when an instruction executes with write-C set. Otherwise C holds its value.
- R4: Z changes only when an instruction executes with write-Z set, and it is then loaded with 1 exactly when the 32-bit result is zero.
- R5: The destination word is written only when an instruction executes with write-result set. Flags can be updated without any memory write.
- R6: With immediate set, the source operand is the 9-bit source field zero-extended to 32 bits. With it clear, the source operand is the word at the source address.
- R7: The instruction executes when predicate bit {C,Z} is 1. Bit 0 covers C=0,Z=0, bit 1 covers C=0,Z=1, bit 2 covers C=1,Z=0 and bit 3 covers C=1,Z=1. So 4'b1111 always executes and 4'b0000 never does.
- R8: MOV (6'h01) gives src. AND (6'h04), OR (6'h05) and XOR (6'h06) give dest op src. These four produce C = 0. SHL (6'h07) and SHR (6'h08) shift dest logically by src[4:0], with C taking dest[31] and dest[0] respectively. Opcode 6'h00 and every unlisted opcode change nothing apart from advancing pc.
- R9: An executed JMP (6'h09) loads pc with the low 9 bits of the source operand. Its result is the address of the following instruction (pc + 1), and it produces C = 0.
- R10: While running, exactly one instruction completes per clock. Every instruction that is not an executed JMP, including one whose predicate fails, advances pc by 1, and pc wraps from 511 to 0.
- R11: A word written by one instruction is what the next fetch from that address returns. Self-modifying code takes effect on the following cycle.
- R12: Address 0x1F0 reads `in_port` and ignores writes. Address 0x1F1 is the output register: it is readable and drives `out_port`. Addresses 0x1F2 to 0x1FF read as zero and ignore writes.
- R13: With `run` low, pc, C and Z hold. The preload port writes only while `run` is low. `peek_data` shows the contents of `peek_addr`, with special registers included, at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 executes one instruction per clock, 0 halts |
| load_we | input | 1 | Preload write strobe, honoured only while halted |
| load_addr | input | 9 | Preload write address |
| load_data | input | 32 | Preload write data |
| peek_addr | input | 9 | Read-back address |
| peek_data | output | 32 | Contents of the read-back address |
| in_port | input | 32 | Value seen at special address 0x1F0 |
| out_port | output | 32 | Output register at special address 0x1F1 |
| pc_o | output | 9 | Current program counter |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |

## Verification
On every cycle, the assertions check the control rules: flags stay put when their write bits are clear or the core is halted, pc steps by one unless a taken JMP redirects it, predicate 0000 leaves flags untouched, a literal jump lands on its field, and reset returns the core to its initial state. The values themselves can only be shown by the bench's scenarios. These cover the arithmetic and logical results and their carry/zero outcomes over a sweep of operand pairs and every opcode, the full predicate table against all four flag states, literal versus memory sources, self-modified instruction words, the special-register decode and the halted preload behaviour.

// File: rtl/pcore_pkg.sv
// pcore_pkg: shared constants, opcode values and instruction layout for
// the predicated microcore. Assumes a fixed 32-bit instruction word with
// 9-bit operand fields.
package pcore_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 9;
    localparam int OPC_W     = 6;
    localparam int PRED_W    = 4;
    localparam int SPR_COUNT = 16;
    localparam int MEM_WORDS = (1 << ADDR_W) - SPR_COUNT;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 6'h00,
        OP_MOV = 6'h01,
        OP_ADD = 6'h02,
        OP_SUB = 6'h03,
        OP_AND = 6'h04,
        OP_OR  = 6'h05,
        OP_XOR = 6'h06,
        OP_SHL = 6'h07,
        OP_SHR = 6'h08,
        OP_JMP = 6'h09
    } opc_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic              wz;
        logic              wc;
        logic              wr;
        logic              imm;
        logic [PRED_W-1:0] pred;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
    } instr_t;

endpackage

// File: rtl/pcore_decode.sv
// pcore_decode: evaluates the execution predicate against the current
// flags and classifies the opcode. Purely combinational; assumes the
// predicate bit index is {C,Z}.
module pcore_decode
    import pcore_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    input  logic [PRED_W-1:0] pred,
    input  logic              c_flag,
    input  logic              z_flag,
    output logic              exec,
    output logic              is_known,
    output logic              is_jump
);

    // Predicate lookup: one enable bit per flag combination.
    always_comb begin
        exec = pred[{c_flag, z_flag}];
    end

    // Opcode classification: only listed operations may change state.
    always_comb begin
        is_jump = (opc == OP_JMP);
        case (opc)
            OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR,
            OP_XOR, OP_SHL, OP_SHR, OP_JMP: is_known = 1'b1;
            default:                        is_known = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcore_alu.sv
// pcore_alu: computes the result and carry for one instruction from the
// destination and source operands. Combinational; logic ops yield C=0.
module pcore_alu
    import pcore_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADDR_W,
    localparam int SH_W = $clog2(DW)
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [DW-1:0]    d_val,
    input  logic [DW-1:0]    s_val,
    input  logic [AW-1:0]    ret_pc,
    output logic [DW-1:0]    result,
    output logic             c_out
);

    logic [DW:0] sum_w;
    logic [DW:0] diff_w;

    // Wide adder and subtractor whose top bit carries the carry/borrow.
    always_comb begin
        sum_w  = {1'b0, d_val} + {1'b0, s_val};
        diff_w = {1'b0, d_val} - {1'b0, s_val};
    end

    // Operation select.
    always_comb begin
        result = d_val;
        c_out  = 1'b0;
        case (opc)
            OP_MOV: result = s_val;
            OP_ADD: begin
                result = sum_w[DW-1:0];
                c_out  = sum_w[DW];
            end
            OP_SUB: begin
                result = diff_w[DW-1:0];
                c_out  = diff_w[DW];
            end
            OP_AND: result = d_val & s_val;
            OP_OR:  result = d_val | s_val;
            OP_XOR: result = d_val ^ s_val;
            OP_SHL: begin
                result = d_val << s_val[SH_W-1:0];
                c_out  = d_val[DW-1];
            end
            OP_SHR: begin
                result = d_val >> s_val[SH_W-1:0];
                c_out  = d_val[0];
            end
            OP_JMP: result = {{(DW-AW){1'b0}}, ret_pc};
            default: begin
                result = d_val;
                c_out  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcore_mem.sv
// pcore_mem: the unified local address space. Plain words occupy the low
// MEM_WORDS addresses; the rest decode to special registers (input port,
// output register, reserved reads-as-zero). Four asynchronous read ports
// (fetch, destination, source, peek) and one synchronous write port.
// Plain words are not reset.
module pcore_mem
    import pcore_pkg::*;
#(
    parameter int DW    = WORD_W,
    parameter int AW    = ADDR_W,
    parameter int WORDS = MEM_WORDS,
    localparam int NRD = 4,
    localparam logic [AW-1:0] MEM_TOP  = AW'(WORDS),
    localparam logic [AW-1:0] SPR_IN   = MEM_TOP,
    localparam logic [AW-1:0] SPR_OUT  = MEM_TOP + AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] fetch_data,
    input  logic [AW-1:0] dst_addr,
    output logic [DW-1:0] dst_data,
    input  logic [AW-1:0] src_addr,
    output logic [DW-1:0] src_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] in_port,
    output logic [DW-1:0] out_port
);

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] out_q;
    logic [AW-1:0] rd_addr [NRD];
    logic [DW-1:0] rd_data [NRD];

    // Collect the read addresses so one decoder per port is generated.
    always_comb begin
        rd_addr[0] = fetch_addr;
        rd_addr[1] = dst_addr;
        rd_addr[2] = src_addr;
        rd_addr[3] = peek_addr;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // Address decode for one read port: plain word or special register.
        always_comb begin
            if (rd_addr[g] < MEM_TOP) begin
                rd_data[g] = mem[rd_addr[g]];
            end else if (rd_addr[g] == SPR_IN) begin
                rd_data[g] = in_port;
            end else if (rd_addr[g] == SPR_OUT) begin
                rd_data[g] = out_q;
            end else begin
                rd_data[g] = '0;
            end
        end
    end

    assign fetch_data = rd_data[0];
    assign dst_data   = rd_data[1];
    assign src_data   = rd_data[2];
    assign peek_data  = rd_data[3];
    assign out_port   = out_q;

    // Plain word write; special addresses never land in the array.
    always_ff @(posedge clk) begin
        if (we && (waddr < MEM_TOP)) begin
            mem[waddr] <= wdata;
        end
    end

    // Output register: reset to zero, loaded by writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (we && (waddr == SPR_OUT)) begin
            out_q <= wdata;
        end
    end

endmodule

// File: rtl/pcore_top.sv
// pcore_top: predicated two-operand microcore. Executes one instruction
// per clock from its local memory while run is high; while halted the
// preload port owns the memory write port. State is pc, C, Z and memory.
module pcore_top
    import pcore_pkg::*;
#(
    parameter int DW    = WORD_W,
    parameter int AW    = ADDR_W,
    parameter int WORDS = MEM_WORDS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    input  logic [DW-1:0] in_port,
    output logic [DW-1:0] out_port,
    output logic [AW-1:0] pc_o,
    output logic          c_o,
    output logic          z_o
);

    logic [AW-1:0] pc_q;
    logic          c_q;
    logic          z_q;
    logic [DW-1:0] fetch_word;
    logic [DW-1:0] dst_data;
    logic [DW-1:0] src_data;
    logic [DW-1:0] src_val;
    logic [DW-1:0] alu_res;
    logic          alu_c;
    logic          exec;
    logic          is_known;
    logic          is_jump;
    logic          act;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] pc_inc;
    instr_t        ins;

    assign ins    = instr_t'(fetch_word);
    assign pc_inc = pc_q + AW'(1);

    pcore_mem #(.DW(DW), .AW(AW), .WORDS(WORDS)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_addr (pc_q),
        .fetch_data (fetch_word),
        .dst_addr   (ins.dst),
        .dst_data   (dst_data),
        .src_addr   (ins.src),
        .src_data   (src_data),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data),
        .we         (mem_we),
        .waddr      (mem_waddr),
        .wdata      (mem_wdata),
        .in_port    (in_port),
        .out_port   (out_port)
    );

    pcore_decode u_dec (
        .opc      (ins.opc),
        .pred     (ins.pred),
        .c_flag   (c_q),
        .z_flag   (z_q),
        .exec     (exec),
        .is_known (is_known),
        .is_jump  (is_jump)
    );

    // Source operand: zero-extended literal or addressed word.
    always_comb begin
        src_val = ins.imm ? {{(DW-AW){1'b0}}, ins.src} : src_data;
    end

    pcore_alu #(.DW(DW), .AW(AW)) u_alu (
        .opc    (ins.opc),
        .d_val  (dst_data),
        .s_val  (src_val),
        .ret_pc (pc_inc),
        .result (alu_res),
        .c_out  (alu_c)
    );

    // An instruction takes effect only when running, predicated in and known.
    assign act = run & exec & is_known;

    // Single write port: the core while running, the preload port when halted.
    always_comb begin
        if (run) begin
            mem_we    = act & ins.wr;
            mem_waddr = ins.dst;
            mem_wdata = alu_res;
        end else begin
            mem_we    = load_we;
            mem_waddr = load_addr;
            mem_wdata = load_data;
        end
    end

    // Program counter: step by one, or redirect on a taken jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= (act && is_jump) ? src_val[AW-1:0] : pc_inc;
        end
    end

    // Condition flags, each gated by its own write bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            if (act && ins.wc) begin
                c_q <= alu_c;
            end
            if (act && ins.wz) begin
                z_q <= (alu_res == '0);
            end
        end
    end

    assign pc_o = pc_q;
    assign c_o  = c_q;
    assign z_o  = z_q;

endmodule

// File: rtl/pcore_sva.sv
// pcore_sva: control-rule checker for pcore_top, attached by bind. Watches
// the fetched instruction fields, pc and flags.
module pcore_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [5:0] opc,
    input logic       wz,
    input logic       wc,
    input logic       imm,
    input logic [3:0] pred,
    input logic [8:0] lit,
    input logic [8:0] pc,
    input logic       c,
    input logic       z
);

    logic exec_now;
    logic taken_jmp;

    assign exec_now  = pred[{c, z}];
    assign taken_jmp = (opc == 6'h09) && exec_now;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pc == 9'd0) && !c && !z); // R1

    AST_NO_WC: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && wc) |=> $stable(c)); // R3

    AST_NO_WZ: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && wz) |=> $stable(z)); // R4

    AST_PRED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pred == 4'b0000) |=> $stable(c) && $stable(z) && (pc == $past(pc) + 9'd1)); // R7

    AST_JMP_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (run && taken_jmp && imm) |=> (pc == $past(lit))); // R9

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !taken_jmp) |=> (pc == $past(pc) + 9'd1)); // R10

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pc) && $stable(c) && $stable(z)); // R13

endmodule

bind pcore_top pcore_sva u_sva (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .opc   (fetch_word[31:26]),
    .wz    (fetch_word[25]),
    .wc    (fetch_word[24]),
    .imm   (fetch_word[22]),
    .pred  (fetch_word[21:18]),
    .lit   (fetch_word[8:0]),
    .pc    (pc_o),
    .c     (c_o),
    .z     (z_o)
);

// File: tb/tb_pcore_top.sv
// tb_pcore_top: self-checking bench. Sweeps opcodes over operand pairs,
// the full predicate table against all flag states, and the jump,
// self-modify, special-register and halt scenarios.
module tb_pcore_top;

    localparam logic [5:0] O_NOP = 6'h00, O_MOV = 6'h01, O_ADD = 6'h02, O_SUB = 6'h03,
                           O_AND = 6'h04, O_OR  = 6'h05, O_XOR = 6'h06, O_SHL = 6'h07,
                           O_SHR = 6'h08, O_JMP = 6'h09;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        load_we = 1'b0;
    logic [8:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [8:0]  peek_addr = '0;
    logic [31:0] peek_data;
    logic [31:0] in_port = '0;
    logic [31:0] out_port;
    logic [8:0]  pc_o;
    logic        c_o;
    logic        z_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcore_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .in_port   (in_port),
        .out_port  (out_port),
        .pc_o      (pc_o),
        .c_o       (c_o),
        .z_o       (z_o)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic wz, input logic wc,
                                        input logic wr, input logic im, input logic [3:0] p,
                                        input logic [8:0] d, input logic [8:0] s);
        return {op, wz, wc, wr, im, p, d, s};
    endfunction

    // Expected {C, Z, result} from the requirement text.
    function automatic logic [33:0] model(input logic [5:0] op, input logic [31:0] d,
                                          input logic [31:0] s);
        logic [32:0] w;
        logic [31:0] r;
        logic        cc;
        cc = 1'b0;
        r  = d;
        case (op)
            O_MOV: r = s;
            O_ADD: begin w = {1'b0, d} + {1'b0, s}; r = w[31:0]; cc = w[32]; end
            O_SUB: begin r = d - s; cc = (d < s); end
            O_AND: r = d & s;
            O_OR:  r = d | s;
            O_XOR: r = d ^ s;
            O_SHL: begin r = d << s[4:0]; cc = d[31]; end
            O_SHR: begin r = d >> s[4:0]; cc = d[0]; end
            default: r = d;
        endcase
        return {cc, (r == 32'd0), r};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ld(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk);
        load_we = 1'b1;
        load_addr = a;
        load_data = v;
        @(posedge clk);
        #1 load_we = 1'b0;
    endtask

    task automatic run_for(input int k);
        @(negedge clk);
        run = 1'b1;
        repeat (k) @(posedge clk);
        #1 run = 1'b0;
    endtask

    task automatic peek(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        peek_addr = a;
        #1 v = peek_data;
    endtask

    logic [5:0]  ops  [8] = '{O_ADD, O_SUB, O_AND, O_OR, O_XOR, O_MOV, O_SHL, O_SHR};
    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    logic [8:0]  lits [4] = '{9'h000, 9'h001, 9'h1FF, 9'h0A5};

    initial begin : main
        logic [31:0] v;
        logic [33:0] e;

        // R1: reset state
        do_reset();
        chk("R1 pc", {23'b0, pc_o}, 32'd0);
        chk("R1 c", {31'b0, c_o}, 32'd0);
        chk("R1 z", {31'b0, z_o}, 32'd0);
        chk("R1 out", out_port, 32'd0);

        // R2 R8 R4 R10: opcode sweep over operand pairs, memory source
        for (int oi = 0; oi < 8; oi++) begin
            for (int ai = 0; ai < 6; ai++) begin
                for (int bi = 0; bi < 6; bi++) begin
                    do_reset();
                    ld(9'd0, enc(ops[oi], 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 9'd10, 9'd11));
                    ld(9'd10, vals[ai]);
                    ld(9'd11, vals[bi]);
                    run_for(1);
                    e = model(ops[oi], vals[ai], vals[bi]);
                    peek(9'd10, v);
                    chk("R2/R8 result", v, e[31:0]);
                    chk("R2/R8 carry", {31'b0, c_o}, {31'b0, e[33]});
                    chk("R4 zero", {31'b0, z_o}, {31'b0, e[32]});
                    chk("R10 pc step", {23'b0, pc_o}, 32'd1);
                end
            end
        end

        // R6: literal source, zero-extended
        for (int oi = 0; oi < 8; oi++) begin
            for (int li = 0; li < 4; li++) begin
                do_reset();
                ld(9'd0, enc(ops[oi], 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 9'd12, lits[li]));
                ld(9'd12, 32'hF0F0_1357);
                ld(9'd13, 32'hFFFF_FFFF);
                run_for(1);
                e = model(ops[oi], 32'hF0F0_1357, {23'b0, lits[li]});
                peek(9'd12, v);
                chk("R6 literal result", v, e[31:0]);
                chk("R6 literal carry", {31'b0, c_o}, {31'b0, e[33]});
            end
        end

        // R3 R4 R5: independent write enables
        do_reset();
        ld(9'd0, enc(O_SUB, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 9'd20, 9'd21));
        ld(9'd1, enc(O_AND, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 9'd22, 9'd0));
        ld(9'd2, enc(O_ADD, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 9'd23, 9'd1));
        ld(9'd20, 32'd0);
        ld(9'd21, 32'd1);
        ld(9'd22, 32'hFF);
        ld(9'd23, 32'd5);
        run_for(1);
        peek(9'd20, v);
        chk("R5 no write", v, 32'd0);
        chk("R3 borrow set", {31'b0, c_o}, 32'd1);
        chk("R4 nonzero", {31'b0, z_o}, 32'd0);
        run_for(1);
        peek(9'd22, v);
        chk("R5 write", v, 32'd0);
        chk("R3 c held", {31'b0, c_o}, 32'd1);
        chk("R4 z set", {31'b0, z_o}, 32'd1);
        run_for(1);
        peek(9'd23, v);
        chk("R5 add write", v, 32'd6);
        chk("R3 c cleared", {31'b0, c_o}, 32'd0);
        chk("R4 z held", {31'b0, z_o}, 32'd1);

        // R7 R10: full predicate table against every flag state
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < 16; p++) begin
                logic [5:0]  fop;
                logic [31:0] fd, fs;
                logic [3:0]  pp;
                pp = 4'(p);
                case (f)
                    0: begin fop = O_ADD; fd = 32'd1; fs = 32'd1; end
                    1: begin fop = O_AND; fd = 32'd5; fs = 32'd0; end
                    2: begin fop = O_SUB; fd = 32'd0; fs = 32'd1; end
                    default: begin fop = O_ADD; fd = 32'hFFFF_FFFF; fs = 32'd1; end
                endcase
                do_reset();
                ld(9'd0, enc(fop, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 9'd20, 9'd21));
                ld(9'd1, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b1, pp, 9'd30, 9'd5));
                ld(9'd20, fd);
                ld(9'd21, fs);
                ld(9'd30, 32'd0);
                run_for(2);
                peek(9'd30, v);
                chk("R7 predicate", v, pp[f] ? 32'd5 : 32'd0);
                chk("R7 flags", {30'b0, c_o, z_o}, 32'(f));
                chk("R10 pc after predicate", {23'b0, pc_o}, 32'd2);
            end
        end

        // R9 R10: jumps, literal and memory source, and a predicated-out jump
        do_reset();
        ld(9'd0, enc(O_JMP, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 9'd40, 9'd7));
        ld(9'd7, enc(O_JMP, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 9'd42, 9'd41));
        ld(9'd3, enc(O_JMP, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 9'd42, 9'd100));
        ld(9'd40, 32'hDEAD);
        ld(9'd41, 32'h0000_0203);
        ld(9'd42, 32'h77);
        run_for(1);
        chk("R9 jump literal pc", {23'b0, pc_o}, 32'd7);
        peek(9'd40, v);
        chk("R9 return address", v, 32'd1);
        run_for(1);
        chk("R9 jump memory pc", {23'b0, pc_o}, 32'd3);
        peek(9'd42, v);
        chk("R5 jump without write", v, 32'h77);
        run_for(1);
        chk("R10 predicated-out jump", {23'b0, pc_o}, 32'd4);

        // R10: pc wraps after address 511
        do_reset();
        ld(9'd0, enc(O_JMP, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 9'd0, 9'h1FF));
        run_for(1);
        chk("R10 jump to top", {23'b0, pc_o}, 32'h1FF);
        run_for(1);
        chk("R10 pc wrap", {23'b0, pc_o}, 32'd0);

        // R11: self-modifying code
        do_reset();
        ld(9'd0, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 9'd1, 9'd50));
        ld(9'd1, 32'd0);
        ld(9'd50, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 9'd60, 9'h055));
        ld(9'd60, 32'd0);
        run_for(2);
        peek(9'd60, v);
        chk("R11 patched instruction ran", v, 32'h55);

        // R8: NOP and an unlisted opcode with all enables set change nothing
        do_reset();
        ld(9'd0, enc(6'h3F, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 9'd90, 9'd91));
        ld(9'd1, enc(O_NOP, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 9'd90, 9'd0));
        ld(9'd90, 32'd7);
        ld(9'd91, 32'd0);
        run_for(2);
        peek(9'd90, v);
        chk("R8 unlisted opcode no write", v, 32'd7);
        chk("R8 unlisted opcode flags", {30'b0, c_o, z_o}, 32'd0);
        chk("R8 unlisted opcode pc", {23'b0, pc_o}, 32'd2);

        // R12: special registers
        do_reset();
        in_port = 32'hCAFE_F00D;
        ld(9'd0, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 9'h1F1, 9'h1AB));
        ld(9'd1, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 9'd70, 9'h1F0));
        ld(9'd2, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 9'h1F0, 9'd3));
        ld(9'd3, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 9'd71, 9'h1F0));
        ld(9'd4, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 9'h1F5, 9'd9));
        ld(9'd5, enc(O_MOV, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 9'd72, 9'h1F5));
        ld(9'd6, enc(O_ADD, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 9'd73, 9'h1F1));
        ld(9'd72, 32'h1234);
        ld(9'd73, 32'd1);
        run_for(7);
        chk("R12 out_port", out_port, 32'h1AB);
        peek(9'd70, v);
        chk("R12 input read", v, 32'hCAFE_F00D);
        peek(9'd71, v);
        chk("R12 input write ignored", v, 32'hCAFE_F00D);
        peek(9'd72, v);
        chk("R12 reserved reads zero", v, 32'd0);
        peek(9'd73, v);
        chk("R12 output readable", v, 32'h1AC);
        peek(9'h1F1, v);
        chk("R13 peek special", v, 32'h1AB);
        do_reset();
        chk("R1 out cleared", out_port, 32'd0);

        // R13: halt holds state; preload ignored while running
        do_reset();
        ld(9'd0, 32'd0);
        ld(9'd1, 32'd0);
        ld(9'd2, 32'd0);
        ld(9'd3, 32'd0);
        ld(9'd80, 32'h600D);
        run_for(3);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R13 pc held", {23'b0, pc_o}, 32'd3);
        run = 1'b1;
        load_we = 1'b1;
        load_addr = 9'd80;
        load_data = 32'hBAD;
        @(posedge clk);
        #1;
        run = 1'b0;
        load_we = 1'b0;
        peek(9'd80, v);
        chk("R13 preload ignored while running", v, 32'h600D);
        chk("R13 pc advanced", {23'b0, pc_o}, 32'd4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule